// File: doc/BRIEF.md
# Lockable Watchdog Register Block

A watchdog down-counter whose configuration registers sit behind a write-protection lock. Software reaches the block through a flat 32-bit register bus with an address, a write strobe, write data and combinational read data. After reset every configuration write is refused. Writes are accepted only after a 32-bit key value has been written to the lock register. Any other value written there closes the lock again. Reading the lock register returns a lock flag, never the data that was written.

While its enable bit is set, the counter decrements once per clock. On a counting cycle that finds it at zero, it sets a sticky timeout flag, drives `irq` high and reloads from the load register. A debug-halt input can freeze the count. A stall-control bit in the test register decides whether the halt is obeyed or ignored.

Top module: `wdl_top`

## Requirements
- R1: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and that offset then reads 0x00000000.
- R2: Writing any other value to offset 0xC00 locks the block, and that offset then reads 0x00000001.
- R3: After reset the registers hold these values:
  - the block is locked;
  - load (0x000) reads 0xFFFFFFFF;
  - count (0x004) reads 0xFFFFFFFF and does not move;
  - control (0x008) reads 0;
  - test (0x418) reads 0;
  - `irq` is low.
- R4: While the block is locked, writes to the load, control and test registers have no effect.
- R5: The test register at 0x418 keeps only bit 8, the stall enable. Every other bit reads zero.
- R6: With the stall bit at 0 and `cpu_halted` high, the count holds its value. Counting resumes from that value once the halt drops.
- R7: With the stall bit at 1, the count keeps decrementing while `cpu_halted` is high.
- R8: Control bit 0 at 0x008 enables counting, one decrement per clock. While it is 0 the count holds. The count reads back at 0x004.
- R9: An unlocked write to the load register also places the written value in the counter on the same edge.
- R10: A counting cycle that finds the count at zero reloads it from the load register and sets a timeout flag. The flag drives `irq` and stays set until reset.
- R11: Reads of offsets other than 0x000, 0x004, 0x008, 0x418 and 0xC00 return zero. Writes to those offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cpu_halted | input | 1 | Debug halt indication from the CPU |
| irq | output | 1 | Sticky timeout interrupt |

## Verification
The hardest case to reach is the edge where a write to the stall bit and an asserted halt meet a running count. The old stall value still governs that edge, and only the next cycle freezes. The stimulus reaches this case by raising the halt while stall is enabled and the count is live. It then clears stall with a single write and reads the count on the following cycles. Two further cases are reached by loading a small count and reading on every cycle: the wrap at zero and the refusal of writes after the lock closes again.

// File: rtl/wdl_pkg.sv
package wdl_pkg;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned STALL_BIT = 8;

  localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_TEST  = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_LOCK  = 12'hC00;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/wdl_lock.sv
module wdl_lock
  import wdl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  logic locked_d;

  always_comb begin
    locked_d = locked;
    if (lock_wr) begin
      locked_d = (wdata != UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
    end else if (lock_wr) begin
      locked <= locked_d;
    end
  end
endmodule

// File: rtl/wdl_regs.sv
module wdl_regs
  import wdl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_wr,
  input  logic              ctrl_wr,
  input  logic              test_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_q,
  output logic              en_q,
  output logic              stall_q
);
  logic [DATA_W-1:0] load_d;
  logic              en_d;
  logic              stall_d;

  always_comb begin
    load_d  = load_wr ? wdata : load_q;
    en_d    = ctrl_wr ? wdata[0] : en_q;
    stall_d = test_wr ? wdata[STALL_BIT] : stall_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '1;
      en_q    <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      if (load_wr) load_q  <= load_d;
      if (ctrl_wr) en_q    <= en_d;
      if (test_wr) stall_q <= stall_d;
    end
  end
endmodule

// File: rtl/wdl_count.sv
module wdl_count
  import wdl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] load_q,
  input  logic              en_q,
  input  logic              stall_q,
  input  logic              cpu_halted,
  output logic [DATA_W-1:0] cnt_q,
  output logic              flag_q
);
  logic [DATA_W-1:0] cnt_d;
  logic              flag_d;
  logic              run;
  logic              cnt_ce;

  // Halt freezes the count only while stall is clear.
  assign run    = en_q && !(cpu_halted && !stall_q);
  assign cnt_ce = load_wr || run;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (load_wr) begin
      cnt_d = wdata;
    end else if (run) begin
      if (cnt_q == '0) begin
        cnt_d  = load_q;
        flag_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      flag_q <= 1'b0;
    end else if (cnt_ce) begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/wdl_top.sv
module wdl_top
  import wdl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cpu_halted,
  output logic              irq
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              lock_q;
  logic              lock_wr;
  logic              load_wr;
  logic              ctrl_wr;
  logic              test_wr;
  logic [DATA_W-1:0] load_q;
  logic              en_q;
  logic              stall_q;
  logic [DATA_W-1:0] cnt_q;
  logic              flag_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign lock_wr = bus_we && (bus_addr == OFS_LOCK);
  assign load_wr = bus_we && !lock_q && (bus_addr == OFS_LOAD);
  assign ctrl_wr = bus_we && !lock_q && (bus_addr == OFS_CTRL);
  assign test_wr = bus_we && !lock_q && (bus_addr == OFS_TEST);

  wdl_lock u_lock (
    .clk(clk), .rst_n(rst_sync_n), .lock_wr(lock_wr),
    .wdata(bus_wdata), .locked(lock_q)
  );

  wdl_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .load_wr(load_wr), .ctrl_wr(ctrl_wr),
    .test_wr(test_wr), .wdata(bus_wdata), .load_q(load_q), .en_q(en_q),
    .stall_q(stall_q)
  );

  wdl_count u_count (
    .clk(clk), .rst_n(rst_sync_n), .load_wr(load_wr), .wdata(bus_wdata),
    .load_q(load_q), .en_q(en_q), .stall_q(stall_q),
    .cpu_halted(cpu_halted), .cnt_q(cnt_q), .flag_q(flag_q)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_LOAD:  bus_rdata = load_q;
      OFS_COUNT: bus_rdata = cnt_q;
      OFS_CTRL:  bus_rdata[0] = en_q;
      OFS_TEST:  bus_rdata[STALL_BIT] = stall_q;
      OFS_LOCK:  bus_rdata[0] = lock_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = flag_q;
endmodule

// File: rtl/wdl_checker.sv
module wdl_checker
  import wdl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              cpu_halted,
  input logic              irq,
  input logic              lock_q,
  input logic              en_q,
  input logic              stall_q,
  input logic [DATA_W-1:0] load_q,
  input logic [DATA_W-1:0] cnt_q
);
  logic load_hit;
  assign load_hit = bus_we && (bus_addr == OFS_LOAD);

  // R1
  a_r1_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_LOCK && bus_wdata == UNLOCK_KEY) |=> !lock_q);

  // R2
  a_r2_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_LOCK && bus_wdata != UNLOCK_KEY) |=> lock_q);

  // R4
  a_r4_locked_load_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && load_hit) |=> $stable(load_q));

  // R4
  a_r4_locked_stall_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && bus_we && bus_addr == OFS_TEST) |=> $stable(stall_q));

  // R6
  a_r6_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halted && !stall_q && !(load_hit && !lock_q)) |=> $stable(cnt_q));

  // R7
  a_r7_stall_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && stall_q && cpu_halted && !load_hit && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R10
  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq);

  // R10
  a_r10_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !cpu_halted && !load_hit && cnt_q == '0)
      |=> (irq && cnt_q == $past(load_q)));
endmodule

bind wdl_top wdl_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .cpu_halted(cpu_halted), .irq(irq),
  .lock_q(lock_q), .en_q(en_q), .stall_q(stall_q), .load_q(load_q),
  .cnt_q(cnt_q)
);

// File: tb/wdl_top_test.sv
module wdl_top_test;
  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        cpu_halted;
  logic        irq;

  int total;
  int bad;
  bit done;
  bit rd_v;

  logic [31:0] exp_q[$];
  logic        irq_q[$];
  string       tag_q[$];

  wdl_top uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_halted(cpu_halted), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Monitor: compare read data and irq away from the active edge.
  always @(negedge clk) begin
    if (rd_v) begin
      logic [31:0] e;
      logic        ei;
      string       t;
      e  = exp_q.pop_front();
      ei = irq_q.pop_front();
      t  = tag_q.pop_front();
      total++;
      if (bus_rdata !== e || irq !== ei) begin
        bad++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 t, bus_rdata, irq, e, ei);
      end
      rd_v = 1'b0;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e,
                    input logic ei, input string t);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1'b0;
    exp_q.push_back(e); irq_q.push_back(ei); tag_q.push_back(t);
    rd_v = 1'b1;
  endtask

  task automatic halt(input logic h);
    @(posedge clk); #1;
    cpu_halted = h;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0; rd_v = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    cpu_halted = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3 reset state
    rd(12'hC00, 32'h1, 1'b0, "R3 lock");
    rd(12'h000, 32'hFFFF_FFFF, 1'b0, "R3 load");
    rd(12'h004, 32'hFFFF_FFFF, 1'b0, "R3 count");
    rd(12'h008, 32'h0, 1'b0, "R3 ctrl");
    rd(12'h418, 32'h0, 1'b0, "R3 test");
    // R11 unmapped read
    rd(12'h100, 32'h0, 1'b0, "R11 unmapped read");

    // R4 writes refused while locked
    wr(12'h000, 32'h10);
    rd(12'h000, 32'hFFFF_FFFF, 1'b0, "R4 locked load");
    wr(12'h008, 32'h1);
    rd(12'h008, 32'h0, 1'b0, "R4 locked ctrl");
    rd(12'h004, 32'hFFFF_FFFF, 1'b0, "R4 count idle");

    // R1 unlock
    wr(12'hC00, 32'h1ACC_E551);
    rd(12'hC00, 32'h0, 1'b0, "R1 unlocked");

    // R5 test register field
    wr(12'h418, 32'hFFFF_FFFF);
    rd(12'h418, 32'h0000_0100, 1'b0, "R5 stall bit only");
    wr(12'h418, 32'h0);
    rd(12'h418, 32'h0, 1'b0, "R5 cleared");

    // R9 load write reloads counter, R8 enable
    wr(12'h000, 32'd100);
    rd(12'h004, 32'd100, 1'b0, "R9 reload on write");
    rd(12'h004, 32'd100, 1'b0, "R8 disabled holds");
    wr(12'h008, 32'h1);
    rd(12'h004, 32'd99, 1'b0, "R8 first decrement");
    rd(12'h004, 32'd98, 1'b0, "R8 second decrement");

    // R6 halt with stall clear
    halt(1'b1);
    rd(12'h004, 32'd97, 1'b0, "R6 frozen");
    rd(12'h004, 32'd97, 1'b0, "R6 still frozen");
    halt(1'b0);
    rd(12'h004, 32'd96, 1'b0, "R6 resumes");

    // R7 halt with stall set
    wr(12'h008, 32'h0);
    wr(12'h418, 32'h100);
    halt(1'b1);
    wr(12'h000, 32'd50);
    rd(12'h004, 32'd50, 1'b0, "R9 reload while halted");
    wr(12'h008, 32'h1);
    rd(12'h004, 32'd49, 1'b0, "R7 counts through halt");
    rd(12'h004, 32'd48, 1'b0, "R7 counts through halt 2");
    wr(12'h418, 32'h0);
    rd(12'h004, 32'd46, 1'b0, "R6 freeze after stall cleared");
    rd(12'h004, 32'd46, 1'b0, "R6 freeze holds");
    halt(1'b0);

    // R10 timeout and reload
    wr(12'h008, 32'h0);
    wr(12'h000, 32'd3);
    rd(12'h004, 32'd3, 1'b0, "R9 small load");
    wr(12'h008, 32'h1);
    rd(12'h004, 32'd2, 1'b0, "R10 count 2");
    rd(12'h004, 32'd1, 1'b0, "R10 count 1");
    rd(12'h004, 32'd0, 1'b0, "R10 zero, no irq yet");
    rd(12'h004, 32'd3, 1'b1, "R10 wrap reload and irq");
    rd(12'h004, 32'd2, 1'b1, "R10 irq sticky");

    // R11 unmapped write ignored
    wr(12'h100, 32'h5);
    rd(12'h100, 32'h0, 1'b1, "R11 unmapped write");
    rd(12'h000, 32'd3, 1'b1, "R11 load untouched");

    // R2 relock, R4 writes refused again
    wr(12'hC00, 32'h1234_5678);
    rd(12'hC00, 32'h1, 1'b1, "R2 relocked");
    wr(12'h000, 32'd7);
    rd(12'h000, 32'd3, 1'b1, "R4 relocked load");
    wr(12'h008, 32'h0);
    rd(12'h008, 32'h1, 1'b1, "R4 relocked ctrl");

    @(posedge clk); @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule